// File: doc/BRIEF.md
# Time-Slot Interchange Switch with Per-Channel Output Modes

This block is the switching core of a non-blocking time-slot interchange. A set of input streams delivers one byte per stream in every channel time slot. The block stores each byte in a data memory at an address taken from the running channel count. For every output stream and channel it then builds the outgoing byte. Serial conversion and bit-rate generation sit outside the block. The stream port supplies one slot strobe per channel period and a frame marker on the first slot of each frame.

A connection memory holds one entry per output stream and channel. Each entry has a 3-bit mode code and an 8-bit low field. The low field is either a source address (input stream and channel) or a byte supplied by the host. The modes are:

- variable delay, for lowest latency;
- constant delay, which keeps frame integrity by reading from a rotating set of three frame buffers;
- a fixed host byte;
- a pseudo-random test sequence;
- high impedance.

A host writes and reads entries through a single-port register interface. The default configuration is 4 streams of 32 channels.

Top module: `tsi_switch`

## Requirements
- R1: Each slot strobe advances the channel count. It wraps to 0 after channel NCHAN-1, and also goes to 0 on any strobe that has `frame_i` high. Every return to channel 0 starts a new frame, and the three data buffers rotate at that point. The input byte of stream s (bits 8s+7..8s of `rx_data_i`) is stored for the current channel of the current frame.
- R2: The connection entry at host address {stream[6:5], channel[4:0]} controls exactly that output stream and channel. Entry bits [10:8] hold the mode and bits [7:0] the low field. In switching modes, low bits [6:5] name the source stream and bits [4:0] the source channel. Any number of entries may name the same source.
- R3: Mode 000 (variable delay) works as follows for output channel d with source channel s. If s+3 <= d, it sends the byte received in slot s of the current frame. Otherwise it sends the byte received in slot s of the previous frame.
- R4: Mode 001 (constant delay) sends the byte received in slot s two frames earlier, whatever the values of s and d.
- R5: Mode 100 sends the entry's low 8 bits in every frame until the entry is rewritten.
- R6: Mode 101 sends the next 8 bits of a 2^15-1 sequence. The state starts at all ones after reset. For each bit, fb = state[14] XOR state[13]; fb shifts into state[0] and into the byte, so the first bit lands in bit 7. Within a slot, streams take bytes in ascending stream order. The state advances only for mode-101 slots.
- R7: Mode 111 and the unused codes 010, 011 and 110 give high impedance: `tx_oe_n_o` is 1 and the byte is 0x00. After reset, every entry reads 0x700 and every output is in high impedance.
- R8: A host write at a clock edge updates the entry for every slot strobe after that edge. A strobe at the same edge still uses the old entry. `host_rdata_o` shows the entry at `host_addr_i` one cycle later, or the written value when a write is made.
- R9: The byte and output enable for channel k appear at the edge that takes the strobe of slot k. They are held unchanged until the next strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slot_stb_i | input | 1 | One pulse per channel time slot |
| frame_i | input | 1 | Marks the strobe of channel 0 |
| rx_data_i | input | NSTREAM*8 | Input bytes for the current slot, stream s at bits 8s+7..8s |
| tx_data_o | output | NSTREAM*8 | Output bytes for the current slot |
| tx_oe_n_o | output | NSTREAM | Active-low output enable, one per stream |
| host_we_i | input | 1 | Host write strobe |
| host_addr_i | input | SW+CW | Entry address {stream, channel} |
| host_wdata_i | input | 3+LOW_W | Entry write data {mode, low field} |
| host_rdata_o | output | 3+LOW_W | Entry read data |

## Verification
The case where two functions fall in the same cycle is a host write that lands on the very edge where a slot strobe reads the entry being written. The bench provokes this twice:
- it rewrites a fixed-byte entry exactly as that slot is strobed;
- it retargets a later slot of the same frame.

The check is that the colliding slot keeps the old byte and the next use takes the new one. Around this case, the bench sweeps every output channel of all four streams over several frames. It compares each slot against a model that keeps its own history of sent bytes and its own copy of the test sequence. A second sample in the idle cycle confirms each value holds across the slot.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
  localparam logic [2:0] MODE_VAR   = 3'b000;
  localparam logic [2:0] MODE_CONST = 3'b001;
  localparam logic [2:0] MODE_PROC  = 3'b100;
  localparam logic [2:0] MODE_PRBS  = 3'b101;
  localparam logic [2:0] MODE_HIZ   = 3'b111;

  localparam int unsigned NBUF        = 3;
  localparam int unsigned VAR_MIN_GAP = 3;

  typedef struct packed {
    logic [14:0] st;
    logic [7:0]  b;
  } prbs_byte_t;

  // eight steps of x^15 + x^14 + 1, first bit into bit 7
  function automatic prbs_byte_t prbs_next_byte(input logic [14:0] s_in);
    prbs_byte_t r;
    logic fb;
    r.st = s_in;
    r.b  = '0;
    for (int i = 0; i < 8; i++) begin
      fb   = r.st[14] ^ r.st[13];
      r.b  = {r.b[6:0], fb};
      r.st = {r.st[13:0], fb};
    end
    return r;
  endfunction

  // buffer index n frames back, modulo NBUF
  function automatic logic [1:0] buf_back(input logic [1:0] b, input logic [1:0] n);
    logic [2:0] t;
    t = {1'b0, b} + 3'd3 - {1'b0, n};
    return (t >= 3'd3) ? 2'(t - 3'd3) : t[1:0];
  endfunction

  // source already arrived this frame with enough margin
  function automatic logic var_fresh(input int unsigned src, input int unsigned dst);
    return (src + VAR_MIN_GAP) <= dst;
  endfunction

  function automatic logic mode_reads_mem(input logic [2:0] m);
    return (m == MODE_VAR) || (m == MODE_CONST);
  endfunction

  function automatic logic mode_drives(input logic [2:0] m);
    return (m == MODE_VAR) || (m == MODE_CONST) || (m == MODE_PROC) || (m == MODE_PRBS);
  endfunction
endpackage

// File: rtl/tsi_slot_ctr.sv
module tsi_slot_ctr #(
  parameter int unsigned NCHAN = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     slot_stb_i,
  input  logic                     frame_i,
  output logic [$clog2(NCHAN)-1:0] slot_chan_o,
  output logic [1:0]               slot_buf_o
);
  localparam int unsigned CW = $clog2(NCHAN);
  localparam logic [CW-1:0] LAST_CH = CW'(NCHAN - 1);

  logic [CW-1:0] chan_q;
  logic [1:0]    buf_q;
  logic          new_frame;

  assign new_frame   = frame_i || (chan_q == LAST_CH);
  assign slot_chan_o = new_frame ? '0 : chan_q + 1'b1;
  assign slot_buf_o  = new_frame ? ((buf_q == 2'd2) ? 2'd0 : buf_q + 2'd1) : buf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_q <= LAST_CH;
      buf_q  <= 2'd2;
    end else if (slot_stb_i) begin
      chan_q <= slot_chan_o;
      buf_q  <= slot_buf_o;
    end
  end

  // R1: buffers rotate on every frame start and only then
  p_buf_rotate_r1: assert property (@(posedge clk) disable iff (!rst_n)
    slot_stb_i && new_frame |=> buf_q != $past(buf_q));
  p_buf_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    slot_stb_i && !new_frame |=> $stable(buf_q));
  p_frame_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    slot_stb_i && frame_i |=> chan_q == '0);
endmodule

// File: rtl/tsi_data_mem.sv
module tsi_data_mem #(
  parameter int unsigned NSTREAM = 4,
  parameter int unsigned NCHAN   = 32
) (
  input  logic                                        clk,
  input  logic                                        rst_n,
  input  logic                                        we_i,
  input  logic [1:0]                                  wbuf_i,
  input  logic [$clog2(NCHAN)-1:0]                    wchan_i,
  input  logic [NSTREAM*8-1:0]                        wdata_i,
  input  logic [NSTREAM-1:0]                          rd_use_i,
  input  logic [NSTREAM-1:0][1:0]                     rbuf_i,
  input  logic [NSTREAM-1:0][$clog2(NSTREAM)-1:0]     rstream_i,
  input  logic [NSTREAM-1:0][$clog2(NCHAN)-1:0]       rchan_i,
  output logic [NSTREAM-1:0][7:0]                     rdata_o
);
  import tsi_pkg::*;
  localparam int unsigned DEPTH = NBUF * NSTREAM * NCHAN;

  logic [7:0] mem [DEPTH];

  function automatic int unsigned dm_addr(input int unsigned b, input int unsigned s,
                                          input int unsigned c);
    return (b * NSTREAM + s) * NCHAN + c;
  endfunction

  always_ff @(posedge clk) begin
    if (we_i) begin
      for (int s = 0; s < NSTREAM; s++)
        mem[dm_addr(32'(wbuf_i), s, 32'(wchan_i))] <= wdata_i[s*8 +: 8];
    end
  end

  for (genvar g = 0; g < NSTREAM; g++) begin : g_rd
    always_comb begin
      rdata_o[g] = mem[dm_addr(32'(rbuf_i[g]) % NBUF, 32'(rstream_i[g]) % NSTREAM,
                               32'(rchan_i[g]) % NCHAN)];
    end

    // R3: a live read never hits the location being written this slot
    p_no_clash_r3: assert property (@(posedge clk) disable iff (!rst_n)
      we_i && rd_use_i[g] |-> !((rbuf_i[g] == wbuf_i) && (rchan_i[g] == wchan_i)));
  end
endmodule

// File: rtl/tsi_conn_mem.sv
module tsi_conn_mem #(
  parameter int unsigned NSTREAM = 4,
  parameter int unsigned NCHAN   = 32,
  parameter int unsigned EW      = 11
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic                                    host_we_i,
  input  logic [$clog2(NSTREAM)+$clog2(NCHAN)-1:0] host_addr_i,
  input  logic [EW-1:0]                           host_wdata_i,
  output logic [EW-1:0]                           host_rdata_o,
  input  logic [$clog2(NCHAN)-1:0]                slot_chan_i,
  output logic [NSTREAM-1:0][EW-1:0]              slot_entry_o
);
  import tsi_pkg::*;
  localparam int unsigned CW    = $clog2(NCHAN);
  localparam int unsigned AW    = $clog2(NSTREAM) + CW;
  localparam int unsigned DEPTH = NSTREAM * NCHAN;
  localparam logic [EW-1:0] CM_RST = {MODE_HIZ, {(EW-3){1'b0}}};

  logic [EW-1:0] cm [DEPTH];
  logic          host_hit;
  int unsigned   host_idx;

  assign host_idx = 32'(host_addr_i[AW-1:CW]) * NCHAN + 32'(host_addr_i[CW-1:0]);
  assign host_hit = (32'(host_addr_i[AW-1:CW]) < NSTREAM) && (32'(host_addr_i[CW-1:0]) < NCHAN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cm[i] <= CM_RST;
      host_rdata_o <= CM_RST;
    end else begin
      if (host_we_i && host_hit) cm[host_idx] <= host_wdata_i;
      if (host_we_i)             host_rdata_o <= host_wdata_i;
      else if (host_hit)         host_rdata_o <= cm[host_idx];
      else                       host_rdata_o <= CM_RST;
    end
  end

  for (genvar g = 0; g < NSTREAM; g++) begin : g_slot
    assign slot_entry_o[g] = cm[g * NCHAN + 32'(slot_chan_i) % NCHAN];
  end

  // R8: read-back right after a write returns the written value
  p_rd_bypass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    host_we_i |=> host_rdata_o == $past(host_wdata_i));
endmodule

// File: rtl/tsi_prbs.sv
module tsi_prbs #(
  parameter int unsigned NSTREAM = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    adv_i,
  input  logic [NSTREAM-1:0]      use_i,
  output logic [NSTREAM-1:0][7:0] byte_o
);
  import tsi_pkg::*;

  logic [14:0] lfsr_q;
  logic [NSTREAM:0][14:0] chain;
  prbs_byte_t [NSTREAM-1:0] step;
  logic any_use;

  assign chain[0] = lfsr_q;
  assign any_use  = |use_i;

  for (genvar g = 0; g < NSTREAM; g++) begin : g_chain
    assign step[g]     = prbs_next_byte(chain[g]);
    assign byte_o[g]   = step[g].b;
    assign chain[g+1]  = use_i[g] ? step[g].st : chain[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lfsr_q <= '1;
    else if (adv_i)  lfsr_q <= chain[NSTREAM];
  end

  // R6: the generator never locks up and moves only for pattern slots
  p_prbs_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != '0);
  p_prbs_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(adv_i && any_use) |=> $stable(lfsr_q));
  p_prbs_move_r6: assert property (@(posedge clk) disable iff (!rst_n)
    adv_i && any_use |=> !$stable(lfsr_q));
endmodule

// File: rtl/tsi_switch.sv
module tsi_switch #(
  parameter int unsigned NSTREAM = 4,
  parameter int unsigned NCHAN   = 32,
  localparam int unsigned SW     = $clog2(NSTREAM),
  localparam int unsigned CW     = $clog2(NCHAN),
  localparam int unsigned LOW_W  = ((SW + CW) > 8) ? (SW + CW) : 8,
  localparam int unsigned EW     = 3 + LOW_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 slot_stb_i,
  input  logic                 frame_i,
  input  logic [NSTREAM*8-1:0] rx_data_i,
  output logic [NSTREAM*8-1:0] tx_data_o,
  output logic [NSTREAM-1:0]   tx_oe_n_o,
  input  logic                 host_we_i,
  input  logic [SW+CW-1:0]     host_addr_i,
  input  logic [EW-1:0]        host_wdata_i,
  output logic [EW-1:0]        host_rdata_o
);
  import tsi_pkg::*;

  // slot events brought out for the checks
  logic [CW-1:0] slot_chan;
  logic [1:0]    slot_buf;

  logic [NSTREAM-1:0][EW-1:0] slot_entry;
  logic [NSTREAM-1:0][2:0]    slot_mode;
  logic [NSTREAM-1:0]         rd_use;
  logic [NSTREAM-1:0]         prbs_use;
  logic [NSTREAM-1:0][1:0]    rd_buf;
  logic [NSTREAM-1:0][SW-1:0] rd_stream;
  logic [NSTREAM-1:0][CW-1:0] rd_chan;
  logic [NSTREAM-1:0][7:0]    mem_byte;
  logic [NSTREAM-1:0][7:0]    prbs_byte;
  logic [NSTREAM-1:0][7:0]    nxt_byte;
  logic [NSTREAM-1:0]         nxt_oe_n;
  logic [NSTREAM-1:0][7:0]    tx_q;
  logic [NSTREAM-1:0]         oe_n_q;

  tsi_slot_ctr #(.NCHAN(NCHAN)) u_ctr (
    .clk(clk), .rst_n(rst_n), .slot_stb_i(slot_stb_i), .frame_i(frame_i),
    .slot_chan_o(slot_chan), .slot_buf_o(slot_buf));

  tsi_conn_mem #(.NSTREAM(NSTREAM), .NCHAN(NCHAN), .EW(EW)) u_cm (
    .clk(clk), .rst_n(rst_n), .host_we_i(host_we_i), .host_addr_i(host_addr_i),
    .host_wdata_i(host_wdata_i), .host_rdata_o(host_rdata_o),
    .slot_chan_i(slot_chan), .slot_entry_o(slot_entry));

  tsi_data_mem #(.NSTREAM(NSTREAM), .NCHAN(NCHAN)) u_dm (
    .clk(clk), .rst_n(rst_n), .we_i(slot_stb_i), .wbuf_i(slot_buf), .wchan_i(slot_chan),
    .wdata_i(rx_data_i), .rd_use_i(rd_use), .rbuf_i(rd_buf), .rstream_i(rd_stream),
    .rchan_i(rd_chan), .rdata_o(mem_byte));

  tsi_prbs #(.NSTREAM(NSTREAM)) u_prbs (
    .clk(clk), .rst_n(rst_n), .adv_i(slot_stb_i), .use_i(prbs_use), .byte_o(prbs_byte));

  for (genvar g = 0; g < NSTREAM; g++) begin : g_out
    assign slot_mode[g] = slot_entry[g][EW-1 -: 3];
    assign rd_chan[g]   = slot_entry[g][CW-1:0];
    assign rd_stream[g] = slot_entry[g][CW+SW-1:CW];
    assign rd_use[g]    = mode_reads_mem(slot_mode[g]);
    assign prbs_use[g]  = (slot_mode[g] == MODE_PRBS);

    always_comb begin
      if (slot_mode[g] == MODE_CONST)
        rd_buf[g] = buf_back(slot_buf, 2'd2);
      else if (var_fresh(32'(rd_chan[g]), 32'(slot_chan)))
        rd_buf[g] = slot_buf;
      else
        rd_buf[g] = buf_back(slot_buf, 2'd1);
    end

    always_comb begin
      case (slot_mode[g])
        MODE_VAR, MODE_CONST: nxt_byte[g] = mem_byte[g];
        MODE_PROC:            nxt_byte[g] = slot_entry[g][7:0];
        MODE_PRBS:            nxt_byte[g] = prbs_byte[g];
        default:              nxt_byte[g] = 8'h00;
      endcase
      nxt_oe_n[g] = !mode_drives(slot_mode[g]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tx_q[g]   <= 8'h00;
        oe_n_q[g] <= 1'b1;
      end else if (slot_stb_i) begin
        tx_q[g]   <= nxt_byte[g];
        oe_n_q[g] <= nxt_oe_n[g];
      end
    end

    assign tx_data_o[g*8 +: 8] = tx_q[g];
    assign tx_oe_n_o[g]        = oe_n_q[g];

    // R7: a released slot carries a zero byte
    p_hiz_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      tx_oe_n_o[g] |-> tx_data_o[g*8 +: 8] == 8'h00);
    // R4: constant delay never reads the buffer being filled
    p_const_old_r4: assert property (@(posedge clk) disable iff (!rst_n)
      slot_stb_i && slot_mode[g] == MODE_CONST |-> rd_buf[g] != slot_buf);
  end

  // R9: outputs only change on a slot strobe
  p_slot_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_stb_i |=> $stable(tx_data_o) && $stable(tx_oe_n_o));
endmodule

// File: tb/tsi_switch_tb.sv
module tsi_switch_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 4;
  localparam int NC = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slot_stb = 1'b0;
  logic        frame = 1'b0;
  logic [31:0] rx = '0;
  logic [31:0] tx;
  logic [3:0]  oe_n;
  logic        host_we = 1'b0;
  logic [6:0]  haddr = '0;
  logic [10:0] hwd = '0;
  logic [10:0] hrd;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int          hist [8][NS][NC];
  logic [10:0] mcm  [NS][NC];
  logic [14:0] ml;
  logic [7:0]  exp_b [NS];
  logic        exp_oe [NS];

  always #(CLK_PERIOD/2) clk = ~clk;

  tsi_switch u_dut (
    .clk(clk), .rst_n(rst_n), .slot_stb_i(slot_stb), .frame_i(frame),
    .rx_data_i(rx), .tx_data_o(tx), .tx_oe_n_o(oe_n),
    .host_we_i(host_we), .host_addr_i(haddr), .host_wdata_i(hwd), .host_rdata_o(hrd));

  function automatic int pat(int f, int s, int c);
    return (f * 37 + s * 64 + c * 5 + 3) & 255;
  endfunction

  task automatic chk(string tag, string what, int got, int expv);
    checks++;
    if (got != expv) begin
      errors++;
      $display("FAIL %s %s got %0h exp %0h", tag, what, got, expv);
    end
  endtask

  task automatic host_write(int s, int c, logic [10:0] d);
    haddr = 7'((s << 5) | c); hwd = d; host_we = 1'b1;
    @(posedge clk); mcm[s][c] = d;
    @(negedge clk); host_we = 1'b0;
    chk("R8", $sformatf("readback after write s%0d c%0d", s, c), int'(hrd), int'(d));
  endtask

  task automatic host_read(int s, int c, logic [10:0] e, string tag);
    haddr = 7'((s << 5) | c);
    @(posedge clk); @(negedge clk);
    chk(tag, $sformatf("read s%0d c%0d", s, c), int'(hrd), int'(e));
  endtask

  // model of one slot, independent of the design structure
  task automatic model_slot(int f, int k);
    logic [2:0] m; int sc, ss, fb;
    for (int o = 0; o < NS; o++) begin
      m = mcm[o][k][10:8]; sc = int'(mcm[o][k][4:0]); ss = int'(mcm[o][k][6:5]);
      exp_oe[o] = 1'b0; exp_b[o] = 8'h00;
      if (m == 3'b000)      exp_b[o] = 8'(hist[((sc + 3 <= k) ? f : f - 1) & 7][ss][sc]);
      else if (m == 3'b001) exp_b[o] = 8'(hist[(f - 2) & 7][ss][sc]);
      else if (m == 3'b100) exp_b[o] = mcm[o][k][7:0];
      else if (m == 3'b101) begin
        for (int b = 0; b < 8; b++) begin
          fb = int'(ml[14] ^ ml[13]);
          exp_b[o] = {exp_b[o][6:0], 1'(fb)};
          ml = {ml[13:0], 1'(fb)};
        end
      end else exp_oe[o] = 1'b1;
    end
  endtask

  function automatic string tag_of(int o, int k);
    logic [2:0] m; string t;
    m = mcm[o][k][10:8];
    if (m == 3'b000)      t = "R3 R1";
    else if (m == 3'b001) t = "R4 R1";
    else if (m == 3'b100) t = "R5";
    else if (m == 3'b101) t = "R6";
    else                  t = "R7";
    if (o == 3 && m == 3'b000) t = {t, " R2"};
    return t;
  endfunction

  task automatic run_frame(int f, bit check, int col_k, int col_s, int col_c, logic [10:0] col_d);
    string tg [NS];
    for (int k = 0; k < NC; k++) begin
      slot_stb = 1'b1; frame = (k == 0);
      for (int s = 0; s < NS; s++) begin
        hist[f & 7][s][k] = pat(f, s, k);
        rx[s*8 +: 8] = 8'(pat(f, s, k));
      end
      if (k == col_k) begin
        haddr = 7'((col_s << 5) | col_c); hwd = col_d; host_we = 1'b1;
      end
      @(posedge clk);
      for (int o = 0; o < NS; o++) tg[o] = tag_of(o, k);
      model_slot(f, k);
      if (k == col_k) mcm[col_s][col_c] = col_d;  // R8: same-edge write applies after this slot
      @(negedge clk);
      slot_stb = 1'b0; frame = 1'b0; host_we = 1'b0;
      if (check) begin
        for (int o = 0; o < NS; o++) begin
          chk(tg[o], $sformatf("f%0d s%0d k%0d byte", f, o, k), int'(tx[o*8 +: 8]), int'(exp_b[o]));
          chk(tg[o], $sformatf("f%0d s%0d k%0d oe_n", f, o, k), int'(oe_n[o]), int'(exp_oe[o]));
        end
      end
      @(posedge clk); @(negedge clk);
      if (check) begin
        for (int o = 0; o < NS; o++)
          chk("R9", $sformatf("f%0d s%0d k%0d hold", f, o, k), int'(tx[o*8 +: 8]), int'(exp_b[o]));
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    ml = 15'h7FFF;
    for (int s = 0; s < NS; s++) for (int c = 0; c < NC; c++) mcm[s][c] = 11'h700;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R7: reset state
    chk("R7", "reset oe_n", int'(oe_n), 15);
    chk("R7", "reset data", int'(tx), 0);
    host_read(1, 17, 11'h700, "R7");

    for (int d = 0; d < NC; d++) begin
      host_write(0, d, {3'b000, 1'b0, 2'(d % 4), 5'((d * 7 + 3) % 32)});
      host_write(1, d, {3'b001, 1'b0, 2'(d % 4), 5'((d * 7 + 3) % 32)});
      case (d % 4)
        1:       host_write(2, d, 11'h700);
        3:       host_write(2, d, {3'b101, 8'h00});
        default: host_write(2, d, {3'b100, 8'((d * 11) ^ 8'h5A)});
      endcase
      case (d % 8)
        4:       host_write(3, d, {3'b010, 8'h11});
        5:       host_write(3, d, {3'b011, 8'h22});
        6:       host_write(3, d, {3'b110, 8'h33});
        7:       host_write(3, d, {3'b001, 1'b0, 2'd3, 5'd31});
        default: host_write(3, d, {3'b000, 1'b0, 2'd2, 5'd5});  // R2 fan-out
      endcase
    end
    host_read(2, 6, {3'b100, 8'((6 * 11) ^ 8'h5A)}, "R8");

    for (int f = 0; f < 5; f++) run_frame(f, f >= 2, -1, 0, 0, 11'h0);
    // R8: collision of host write with the slot reading the same entry
    run_frame(5, 1'b1, 10, 2, 10, {3'b100, 8'hC3});
    run_frame(6, 1'b1, 3, 0, 20, {3'b101, 8'h00});
    run_frame(7, 1'b1, -1, 0, 0, 11'h0);
    host_read(2, 10, {3'b100, 8'hC3}, "R8");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule